// File: doc/BRIEF.md
# Eight-Point Integer Inverse Transform Pass

This block runs one one-dimensional pass of the 8x8 integer inverse transform used in H.264 video decoding. It takes eight signed 16-bit coefficients, lanes d0 to d7, and returns eight signed 16-bit results. Every scaling step is an arithmetic right shift, or a shift plus an add, so the datapath has no multipliers. All sums and differences are kept at 16 bits and wrap. No saturation is applied anywhere. Final rounding, transposition and pixel reconstruction are left to the logic around the block. Two passes with a transpose between them make the full 2-D transform.

The coefficient vector enters through a valid/ready stream port, and the result leaves through another one. There is one register stage. An accepted vector appears on the output one clock later. Back-pressure works as follows. While the output holds a result that the sink has not taken, the output is frozen and the input stops accepting. The result register can be refilled in the same cycle that the sink takes its contents, so with the sink always ready the block accepts one vector per clock.

Top module: `idct8_pass`

## Requirements
- R1: After reset, out_valid is 0 and in_ready is 1.
- R2: The even inputs form a0 = d0 + d4 and a4 = d0 - d4.
- R3: The even inputs also form a6 = d2 + (d6 >>> 1) and a2 = (d2 >>> 1) - d6, where >>> is an arithmetic right shift. The next even stage gives b0 = a0 + a6, b6 = a0 - a6, b2 = a4 + a2 and b4 = a4 - a2.
- R4: The odd inputs form a1 = d5 - d3 - d7 - (d7>>>1), a3 = d1 + d7 - d3 - (d3>>>1), a5 = d7 - d1 + d5 + (d5>>>1) and a7 = d3 + d5 + d1 + (d1>>>1). The 1.5x terms are built from a shift and an add.
- R5: The odd cross terms are b1 = (a7>>>2) + a1, b7 = a7 - (a1>>>2), b3 = a3 + (a5>>>2) and b5 = (a3>>>2) - a5.
- R6: The outputs are paired as follows: out0 = b0 + b7, out7 = b0 - b7, out1 = b2 + b5, out6 = b2 - b5, out2 = b4 + b3, out5 = b4 - b3, out3 = b6 + b1, out4 = b6 - b1. Lane k of each bus carries index k.
- R7: Every intermediate value and every output is a 16-bit two's complement value that wraps on overflow. No value is clamped. For example, d0 = 32767 with d4 = 1 gives out0 = -32768.
- R8: A vector is accepted on a clock edge where in_valid and in_ready are both 1. Its result appears at the next edge, with out_valid = 1.
- R9: While out_valid is 1 and out_ready is 0, out_valid stays 1 and out_data stays unchanged.
- R10: in_ready equals (not out_valid) or out_ready. A vector offered while in_ready is 0 is not taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input vector present |
| in_ready | output | 1 | Block can take an input vector |
| in_coef | input | 8x16 | Coefficients; lane k is dk, signed |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Sink takes the result |
| out_data | output | 8x16 | Results; lane k is outk, signed |

## Verification
The hardest case to reach from the ports is a wrap deep inside the butterfly. An intermediate value can overflow in the odd stage, or in the cross terms, while the inputs still look moderate. A wrong width or a missing sign extension can therefore stay hidden under small inputs. To reach these cases, the stimulus includes vectors made only of the extreme values -32768 and 32767 in several sign patterns. It also includes random full-range vectors, which overflow intermediates often. Each result is compared with a 16-bit behavioural model. The stall case is also driven on purpose: the sink holds off while a new vector is offered, which shows that the output is frozen and the offered vector is dropped.

// File: rtl/idct8_pkg.sv
package idct8_pkg;
  localparam int LANES = 8;
  localparam int HALF  = LANES / 2;
endpackage

// File: rtl/idct8_even.sv
module idct8_even #(
  parameter int W = 16
) (
  input  logic signed [W-1:0] d0,
  input  logic signed [W-1:0] d2,
  input  logic signed [W-1:0] d4,
  input  logic signed [W-1:0] d6,
  output logic signed [W-1:0] b0,
  output logic signed [W-1:0] b2,
  output logic signed [W-1:0] b4,
  output logic signed [W-1:0] b6
);
  logic signed [W-1:0] a0, a2, a4, a6;

  // first even stage, R2 and R3
  always_comb begin
    a0 = d0 + d4;
    a4 = d0 - d4;
    a6 = d2 + (d6 >>> 1);
    a2 = (d2 >>> 1) - d6;
  end

  // second even stage, R3
  always_comb begin
    b0 = a0 + a6;
    b6 = a0 - a6;
    b2 = a4 + a2;
    b4 = a4 - a2;
  end
endmodule

// File: rtl/idct8_odd.sv
module idct8_odd #(
  parameter int W = 16
) (
  input  logic signed [W-1:0] d1,
  input  logic signed [W-1:0] d3,
  input  logic signed [W-1:0] d5,
  input  logic signed [W-1:0] d7,
  output logic signed [W-1:0] b1,
  output logic signed [W-1:0] b3,
  output logic signed [W-1:0] b5,
  output logic signed [W-1:0] b7
);
  logic signed [W-1:0] m1, m3, m5, m7;
  logic signed [W-1:0] a1, a3, a5, a7;

  // 1.5x built from a shift and an add, R4
  always_comb begin
    m1 = d1 + (d1 >>> 1);
    m3 = d3 + (d3 >>> 1);
    m5 = d5 + (d5 >>> 1);
    m7 = d7 + (d7 >>> 1);
  end

  always_comb begin
    a1 = d5 - d3 - m7;
    a3 = d1 + d7 - m3;
    a5 = d7 - d1 + m5;
    a7 = d3 + d5 + m1;
  end

  // quarter-shift cross terms, R5
  always_comb begin
    b1 = (a7 >>> 2) + a1;
    b7 = a7 - (a1 >>> 2);
    b3 = a3 + (a5 >>> 2);
    b5 = (a3 >>> 2) - a5;
  end
endmodule

// File: rtl/idct8_merge.sv
module idct8_merge #(
  parameter int W = 16
) (
  input  logic [idct8_pkg::HALF-1:0][W-1:0]  even_i,
  input  logic [idct8_pkg::HALF-1:0][W-1:0]  odd_i,
  output logic [idct8_pkg::LANES-1:0][W-1:0] res_o
);
  localparam int LAST = idct8_pkg::LANES - 1;

  // lane k and lane LAST-k share one sum/difference pair, R6
  for (genvar k = 0; k < idct8_pkg::HALF; k++) begin : g_pair
    logic signed [W-1:0] e_s, o_s;
    assign e_s = even_i[k];
    assign o_s = odd_i[k];
    assign res_o[k]        = e_s + o_s;
    assign res_o[LAST - k] = e_s - o_s;
  end
endmodule

// File: rtl/idct8_pass.sv
module idct8_pass #(
  parameter int W = 16
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                in_valid,
  output logic                                in_ready,
  input  logic [idct8_pkg::LANES-1:0][W-1:0]  in_coef,
  output logic                                out_valid,
  input  logic                                out_ready,
  output logic [idct8_pkg::LANES-1:0][W-1:0]  out_data
);
  import idct8_pkg::*;

  logic signed [W-1:0] b0, b1, b2, b3, b4, b5, b6, b7;
  logic [HALF-1:0][W-1:0]  even_v, odd_v;
  logic [LANES-1:0][W-1:0] result;
  logic                    take;

  idct8_even #(.W(W)) u_even (
    .d0(in_coef[0]), .d2(in_coef[2]), .d4(in_coef[4]), .d6(in_coef[6]),
    .b0(b0), .b2(b2), .b4(b4), .b6(b6)
  );

  idct8_odd #(.W(W)) u_odd (
    .d1(in_coef[1]), .d3(in_coef[3]), .d5(in_coef[5]), .d7(in_coef[7]),
    .b1(b1), .b3(b3), .b5(b5), .b7(b7)
  );

  // lane k pairs even term with odd partner: (b0,b7) (b2,b5) (b4,b3) (b6,b1)
  assign even_v = {b6, b4, b2, b0};
  assign odd_v  = {b1, b3, b5, b7};

  idct8_merge #(.W(W)) u_merge (
    .even_i(even_v),
    .odd_i (odd_v),
    .res_o (result)
  );

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      if (take) begin
        out_valid <= 1'b1;
        out_data  <= result;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end

  // R8
  accept_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

  // R9
  stall_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> out_valid);

  // R9
  stall_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> $stable(out_data));

  // R10
  ready_rule_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |-> (out_valid && !out_ready));

  // R8
  idle_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_valid && out_ready) |=> !out_valid);
endmodule

// File: tb/idct8_pass_bench.sv
module idct8_pass_bench;
  localparam int W = 16;
  localparam int N = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [N-1:0][W-1:0] in_coef = '0;
  logic out_valid;
  logic out_ready = 1'b1;
  logic [N-1:0][W-1:0] out_data;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  idct8_pass #(.W(W)) u_idct8_pass (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_coef(in_coef),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
  );

  // hand-computed table: d-lanes in, expected out-lanes
  localparam int NT = 3;
  localparam shortint TIN [NT][N] = '{
    '{64, 0, 0, 0, 0, 0, 0, 0},
    '{0, 4, 0, 0, 0, 0, 0, 0},
    '{32767, 0, 0, 0, 1, 0, 0, 0}
  };
  localparam shortint TEXP [NT][N] = '{
    '{64, 64, 64, 64, 64, 64, 64, 64},
    '{6, 5, 3, 1, -1, -3, -5, -6},
    '{-32768, 32766, 32766, -32768, -32768, 32766, 32766, -32768}
  };

  typedef logic [N-1:0][W-1:0] vec_t;

  function automatic vec_t model(vec_t d);
    shortint x [N];
    shortint a0, a2, a4, a6, a1, a3, a5, a7;
    shortint b0, b1, b2, b3, b4, b5, b6, b7;
    vec_t r;
    for (int k = 0; k < N; k++) x[k] = shortint'(d[k]);
    a0 = x[0] + x[4];
    a4 = x[0] - x[4];
    a6 = x[2] + (x[6] >>> 1);
    a2 = (x[2] >>> 1) - x[6];
    a1 = x[5] - x[3] - x[7] - (x[7] >>> 1);
    a3 = x[1] + x[7] - x[3] - (x[3] >>> 1);
    a5 = x[7] - x[1] + x[5] + (x[5] >>> 1);
    a7 = x[3] + x[5] + x[1] + (x[1] >>> 1);
    b1 = (a7 >>> 2) + a1;
    b7 = a7 - (a1 >>> 2);
    b3 = a3 + (a5 >>> 2);
    b5 = (a3 >>> 2) - a5;
    b0 = a0 + a6;
    b6 = a0 - a6;
    b2 = a4 + a2;
    b4 = a4 - a2;
    r[0] = b0 + b7; r[7] = b0 - b7;
    r[1] = b2 + b5; r[6] = b2 - b5;
    r[2] = b4 + b3; r[5] = b4 - b3;
    r[3] = b6 + b1; r[4] = b6 - b1;
    return r;
  endfunction

  task automatic check_vec(string req, vec_t got, vec_t exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic check_bit(string req, logic got, logic exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%b exp=%b", req, got, exp);
    end
  endtask

  // push one vector with sink ready, check result one clock later (R8)
  task automatic push(vec_t d, vec_t exp, string req);
    @(negedge clk);
    in_coef  = d;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check_bit({req, " R8 valid"}, out_valid, 1'b1);
    check_vec(req, out_data, exp);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : main
    vec_t v, hold;
    repeat (3) @(negedge clk);
    // R1 reset state
    check_bit("R1 out_valid", out_valid, 1'b0);
    check_bit("R1 in_ready", in_ready, 1'b1);
    rst_n = 1'b1;

    // table walk: R2/R3 even path, R4/R5 odd path, R6 pairing, R7 wrap
    for (int i = 0; i < NT; i++) begin
      vec_t e;
      for (int k = 0; k < N; k++) begin
        v[k] = TIN[i][k];
        e[k] = TEXP[i][k];
      end
      push(v, e, i == 0 ? "R2 R3 dc" : (i == 1 ? "R4 R5 R6 odd" : "R7 wrap"));
    end

    // extreme sign patterns, R7
    for (int p = 0; p < 6; p++) begin
      for (int k = 0; k < N; k++) begin
        case (p)
          0: v[k] = 16'h7fff;
          1: v[k] = 16'h8000;
          2: v[k] = k[0] ? 16'h8000 : 16'h7fff;
          3: v[k] = k[0] ? 16'h7fff : 16'h8000;
          4: v[k] = (k < 4) ? 16'h7fff : 16'h8000;
          default: v[k] = (k == p) ? 16'h8000 : 16'h0000;
        endcase
      end
      push(v, model(v), "R7 extreme");
    end

    // random full-range vectors, R3 R4 R5 R6
    for (int i = 0; i < 40; i++) begin
      for (int k = 0; k < N; k++) v[k] = W'($urandom);
      push(v, model(v), "R4 R5 R6 random");
    end

    // back-to-back throughput, R8 R10
    @(negedge clk);
    for (int i = 0; i < 4; i++) begin
      for (int k = 0; k < N; k++) v[k] = W'(i * 100 + k * 7);
      in_coef  = v;
      in_valid = 1'b1;
      hold = model(v);
      @(negedge clk);
      check_bit("R10 ready while draining", in_ready, 1'b1);
      check_vec("R8 streaming", out_data, hold);
    end
    in_valid = 1'b0;
    @(negedge clk);
    check_bit("R8 drained", out_valid, 1'b0);

    // stall: R9 hold, R10 drop
    out_ready = 1'b0;
    for (int k = 0; k < N; k++) v[k] = W'(16'h1234 + k);
    hold = model(v);
    in_coef  = v;
    in_valid = 1'b1;
    @(negedge clk);
    for (int k = 0; k < N; k++) in_coef[k] = W'(16'h8000 + k);
    for (int c = 0; c < 2; c++) begin
      @(negedge clk);
      check_bit("R10 in_ready low", in_ready, 1'b0);
      check_bit("R9 valid held", out_valid, 1'b1);
      check_vec("R9 data held", out_data, hold);
    end
    in_valid  = 1'b0;
    out_ready = 1'b1;
    @(negedge clk);
    check_bit("R10 stalled offer dropped", out_valid, 1'b0);
    check_vec("R10 data unchanged", out_data, hold);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule